// File: doc/BRIEF.md
# Clock Reference Switchover Controller

This block decides which of two clock references, primary or secondary, feeds a downstream PLL. In manual operation the choice comes from a configuration bit or from an external select pin. In automatic operation the block watches a per-reference "frequency good" flag and moves away from a failed primary. It can return to the primary when that reference recovers, or it can stay on the secondary. Every changeover passes through a deglitch stage. That stage holds the old selection until the new request has been steady for a programmable number of cycles, so the PLL never sees a runt pulse. The stage can be bypassed.

A holdover controller tells the PLL to freeze its control loop when the selected reference is lost. Control comes either from an internal rule, which requires that lock was seen earlier and that the lock-pin comparator agrees, or directly from an external hold pin. A monitor multiplexer routes one of several level status signals to a single output pin. All configuration fields arrive as parallel inputs.

Top module: `refsw_ctrl`

## Requirements
- R1: With automatic switchover off, the selection follows `ref_sel_pin` when `cfg_use_pin`=1 and follows `cfg_sel_secondary` when `cfg_use_pin`=0. `sel_secondary`=1 means the secondary reference is in use.
- R2: In automatic mode with `pri_good`=0 and `sec_good`=1, the block moves to the secondary. With `cfg_stay_secondary`=0 it moves back to the primary once `pri_good` returns to 1.
- R3: With `cfg_stay_secondary`=1 in automatic mode, the block stays on the secondary after a switchover, even when the primary recovers.
- R4: When `cfg_diff_mode`=1, automatic switching is inhibited and the manual selection of R1 applies.
- R5: With automatic mode effective (`cfg_auto`=1, `cfg_diff_mode`=0), both power enables are 1. Otherwise `pwr_pri` equals `cfg_pwr_pri` and `pwr_sec` equals `cfg_pwr_sec`.
- R6: In automatic mode with both references bad, the current selection is kept.
- R7: With `cfg_deglitch_off`=0, a new selection appears on `sel_secondary` only at the DGL_CYCLES-th rising edge (default 8) of an uninterrupted request. A request withdrawn earlier leaves the selection unchanged.
- R8: With `cfg_deglitch_off`=1, a changed request appears on `sel_secondary` after one rising edge.
- R9: With `cfg_hold_en`=0, `holdover` is 0.
- R10: With `cfg_hold_en`=1 and `cfg_hold_ext`=1, `holdover` follows `hold_pin` with one cycle of delay.
- R11: With `cfg_hold_en`=1 and `cfg_hold_ext`=0, `holdover` goes to 1 one cycle after the selected reference's good flag is 0. This needs two more conditions: `dld` has been 1 at some point since reset, and the comparator level is 1. The comparator level is `lock_cmp` when `cfg_cmp_en`=1 and a constant 1 otherwise.
- R12: After reset, `sel_secondary`=0 and `holdover`=0.
- R13: `mon_out` is chosen by `cfg_mon_sel` as follows. 0 gives pri_good AND sec_good. 1 gives dld AND selected-reference good AND clk_good. 2 gives NOT clk_good. 3 gives 1 when the primary is selected. 4 gives NOT dld. 5 gives NOT holdover. 6 gives NOT lock_cmp. 7 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_deglitch_off | input | 1 | 1 bypasses the changeover deglitch |
| cfg_sel_secondary | input | 1 | Manual register selection, 1 = secondary |
| cfg_use_pin | input | 1 | Manual selection taken from ref_sel_pin |
| cfg_auto | input | 1 | Automatic switchover enable |
| cfg_stay_secondary | input | 1 | Non-revertive automatic switchover |
| cfg_pwr_pri | input | 1 | Primary power bit (manual mode) |
| cfg_pwr_sec | input | 1 | Secondary power bit (manual mode) |
| cfg_diff_mode | input | 1 | Differential reference mode, inhibits auto |
| cfg_cmp_en | input | 1 | Use lock-pin comparator level |
| cfg_hold_en | input | 1 | Holdover enable |
| cfg_hold_ext | input | 1 | Holdover driven by hold_pin |
| cfg_mon_sel | input | 3 | Monitor output select code |
| ref_sel_pin | input | 1 | External reference select pin |
| pri_good | input | 1 | Primary reference frequency good |
| sec_good | input | 1 | Secondary reference frequency good |
| clk_good | input | 1 | Feedback clock frequency good |
| dld | input | 1 | Digital lock detect |
| lock_cmp | input | 1 | Lock-pin comparator level |
| hold_pin | input | 1 | External hold request |
| sel_secondary | output | 1 | Committed selection, 1 = secondary |
| pwr_pri | output | 1 | Primary reference power enable |
| pwr_sec | output | 1 | Secondary reference power enable |
| holdover | output | 1 | Holdover active |
| mon_out | output | 1 | Monitor mux output |

## Verification
The hardest case to reach is internal holdover. It needs the lock history latched, then loss of the reference that is actually committed, with the comparator qualifying the result. The stimulus first checks that a lost reference with no earlier lock never asserts holdover, right after reset. It then raises lock detect, drops the committed reference, and steps the comparator enable and level one at a time. Deglitch timing is probed by sampling one cycle before and at the expected switch edge, and by withdrawing a request partway through the count.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

   typedef enum logic {
      REF_PRI = 1'b0,
      REF_SEC = 1'b1
   } ref_e;

   typedef enum logic [2:0] {
      MON_BOTH_GOOD = 3'd0,
      MON_LOCK_ALL  = 3'd1,
      MON_CLK_BAD   = 3'd2,
      MON_SEL_PRI   = 3'd3,
      MON_UNLOCKED  = 3'd4,
      MON_HOLD_N    = 3'd5,
      MON_CMP_N     = 3'd6,
      MON_ZERO      = 3'd7
   } mon_e;

endpackage

// File: rtl/refsw_select.sv
module refsw_select
   import refsw_pkg::*;
(
   input  logic cfg_sel_secondary,
   input  logic cfg_use_pin,
   input  logic auto_eff,
   input  logic cfg_stay_secondary,
   input  logic ref_sel_pin,
   input  logic pri_good,
   input  logic sec_good,
   input  ref_e cur,
   output ref_e target
);

   ref_e manual_sel;

   always_comb begin
      manual_sel = cfg_use_pin ? ref_e'(ref_sel_pin) : ref_e'(cfg_sel_secondary);
      if (!auto_eff) begin
         target = manual_sel;
      end else if (cur == REF_PRI) begin
         target = (!pri_good && sec_good) ? REF_SEC : REF_PRI;
      end else if (cfg_stay_secondary) begin
         target = REF_SEC;
      end else begin
         target = pri_good ? REF_PRI : REF_SEC;
      end
   end

endmodule

// File: rtl/refsw_deglitch.sv
module refsw_deglitch
   import refsw_pkg::*;
#(
   parameter int DGL_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bypass,
   input  ref_e target,
   output ref_e cur
);

   localparam int CNT_W = (DGL_CYCLES > 2) ? $clog2(DGL_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DGL_CYCLES - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur <= REF_PRI;
         cnt <= '0;
      end else if (target == cur) begin
         cnt <= '0;
      end else if (bypass || cnt == CNT_LAST) begin
         cur <= target;
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R7: selection never moves unless a differing request was present
   assert_settle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cur != $past(cur)) |-> ($past(target) != $past(cur)));

   // R8: bypass commits a differing request at the next edge
   assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bypass && target != cur) |=> (cur == $past(target)));

endmodule

// File: rtl/refsw_holdover.sv
module refsw_holdover (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_en,
   input  logic hold_ext,
   input  logic hold_pin,
   input  logic cmp_en,
   input  logic lock_cmp,
   input  logic dld,
   input  logic sel_good,
   output logic holdover
);

   logic locked_seen;
   logic lock_lvl;

   assign lock_lvl = cmp_en ? lock_cmp : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_seen <= 1'b0;
         holdover    <= 1'b0;
      end else begin
         if (dld) locked_seen <= 1'b1;
         if (!hold_en)      holdover <= 1'b0;
         else if (hold_ext) holdover <= hold_pin;
         else               holdover <= ~sel_good & lock_lvl & locked_seen;
      end
   end

   assert_hold_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_en |=> !holdover);

   assert_hold_ext_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_en && hold_ext) |=> (holdover == $past(hold_pin)));

   // R11: internal holdover never asserts while the selected reference is good
   assert_hold_good_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_en && !hold_ext && sel_good) |=> !holdover);

endmodule

// File: rtl/refsw_monitor.sv
module refsw_monitor
   import refsw_pkg::*;
#(
   parameter bit MON_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sel,
   input  logic       pri_good,
   input  logic       sec_good,
   input  logic       clk_good,
   input  logic       dld,
   input  logic       lock_cmp,
   input  logic       sel_good,
   input  ref_e       cur,
   input  logic       holdover,
   output logic       mon_out
);

   logic mon_d;

   always_comb begin
      unique case (mon_e'(sel))
         MON_BOTH_GOOD: mon_d = pri_good & sec_good;
         MON_LOCK_ALL:  mon_d = dld & sel_good & clk_good;
         MON_CLK_BAD:   mon_d = ~clk_good;
         MON_SEL_PRI:   mon_d = (cur == REF_PRI);
         MON_UNLOCKED:  mon_d = ~dld;
         MON_HOLD_N:    mon_d = ~holdover;
         MON_CMP_N:     mon_d = ~lock_cmp;
         default:       mon_d = 1'b0;
      endcase
   end

   generate
      if (MON_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mon_out <= 1'b0;
            else        mon_out <= mon_d;
         end
      end else begin : g_comb
         assign mon_out = mon_d;
      end
   endgenerate

endmodule

// File: rtl/refsw_ctrl.sv
module refsw_ctrl
   import refsw_pkg::*;
#(
   parameter int DGL_CYCLES = 8,
   parameter bit MON_REG    = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_deglitch_off,
   input  logic       cfg_sel_secondary,
   input  logic       cfg_use_pin,
   input  logic       cfg_auto,
   input  logic       cfg_stay_secondary,
   input  logic       cfg_pwr_pri,
   input  logic       cfg_pwr_sec,
   input  logic       cfg_diff_mode,
   input  logic       cfg_cmp_en,
   input  logic       cfg_hold_en,
   input  logic       cfg_hold_ext,
   input  logic [2:0] cfg_mon_sel,
   input  logic       ref_sel_pin,
   input  logic       pri_good,
   input  logic       sec_good,
   input  logic       clk_good,
   input  logic       dld,
   input  logic       lock_cmp,
   input  logic       hold_pin,
   output logic       sel_secondary,
   output logic       pwr_pri,
   output logic       pwr_sec,
   output logic       holdover,
   output logic       mon_out
);

   generate
      if (DGL_CYCLES < 2) begin : g_bad_dgl
         $error("refsw_ctrl: DGL_CYCLES must be at least 2");
      end
   endgenerate

   logic auto_eff;
   logic sel_good;
   ref_e target;
   ref_e cur;

   assign auto_eff      = cfg_auto & ~cfg_diff_mode;
   assign sel_secondary = (cur == REF_SEC);
   assign sel_good      = (cur == REF_SEC) ? sec_good : pri_good;
   assign pwr_pri       = auto_eff | cfg_pwr_pri;
   assign pwr_sec       = auto_eff | cfg_pwr_sec;

   refsw_select u_select (
      .cfg_sel_secondary (cfg_sel_secondary),
      .cfg_use_pin       (cfg_use_pin),
      .auto_eff          (auto_eff),
      .cfg_stay_secondary(cfg_stay_secondary),
      .ref_sel_pin       (ref_sel_pin),
      .pri_good          (pri_good),
      .sec_good          (sec_good),
      .cur               (cur),
      .target            (target)
   );

   refsw_deglitch #(.DGL_CYCLES(DGL_CYCLES)) u_deglitch (
      .clk   (clk),
      .rst_n (rst_n),
      .bypass(cfg_deglitch_off),
      .target(target),
      .cur   (cur)
   );

   refsw_holdover u_holdover (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold_en (cfg_hold_en),
      .hold_ext(cfg_hold_ext),
      .hold_pin(hold_pin),
      .cmp_en  (cfg_cmp_en),
      .lock_cmp(lock_cmp),
      .dld     (dld),
      .sel_good(sel_good),
      .holdover(holdover)
   );

   refsw_monitor #(.MON_REG(MON_REG)) u_monitor (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (cfg_mon_sel),
      .pri_good(pri_good),
      .sec_good(sec_good),
      .clk_good(clk_good),
      .dld     (dld),
      .lock_cmp(lock_cmp),
      .sel_good(sel_good),
      .cur     (cur),
      .holdover(holdover),
      .mon_out (mon_out)
   );

   assert_stay_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_eff && cfg_stay_secondary && sel_secondary) |=> sel_secondary);

   assert_keep_both_bad_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_eff && !pri_good && !sec_good) |=> $stable(sel_secondary));

endmodule

// File: tb/refsw_ctrl_tb_top.sv
module refsw_ctrl_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_deglitch_off = 0, cfg_sel_secondary = 0, cfg_use_pin = 0, cfg_auto = 0;
   logic cfg_stay_secondary = 0, cfg_pwr_pri = 0, cfg_pwr_sec = 0, cfg_diff_mode = 0;
   logic cfg_cmp_en = 0, cfg_hold_en = 0, cfg_hold_ext = 0;
   logic [2:0] cfg_mon_sel = 3'd0;
   logic ref_sel_pin = 0, pri_good = 1, sec_good = 1, clk_good = 1, dld = 0, lock_cmp = 0, hold_pin = 0;
   logic sel_secondary, pwr_pri, pwr_sec, holdover, mon_out;

   int vectors = 0;
   int miscompares = 0;

   always #5 clk = ~clk;

   refsw_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_deglitch_off(cfg_deglitch_off), .cfg_sel_secondary(cfg_sel_secondary),
      .cfg_use_pin(cfg_use_pin), .cfg_auto(cfg_auto), .cfg_stay_secondary(cfg_stay_secondary),
      .cfg_pwr_pri(cfg_pwr_pri), .cfg_pwr_sec(cfg_pwr_sec), .cfg_diff_mode(cfg_diff_mode),
      .cfg_cmp_en(cfg_cmp_en), .cfg_hold_en(cfg_hold_en), .cfg_hold_ext(cfg_hold_ext),
      .cfg_mon_sel(cfg_mon_sel), .ref_sel_pin(ref_sel_pin), .pri_good(pri_good),
      .sec_good(sec_good), .clk_good(clk_good), .dld(dld), .lock_cmp(lock_cmp),
      .hold_pin(hold_pin), .sel_secondary(sel_secondary), .pwr_pri(pwr_pri),
      .pwr_sec(pwr_sec), .holdover(holdover), .mon_out(mon_out)
   );

   task automatic chk(input logic act, input logic exp, input string req);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   function automatic logic mon_exp(input int code, input logic p, input logic s,
                                    input logic c, input logic d, input logic l,
                                    input logic on_sec, input logic h);
      logic sg;
      sg = on_sec ? s : p;
      case (code)
         0: return p & s;
         1: return d & sg & c;
         2: return ~c;
         3: return ~on_sec;
         4: return ~d;
         5: return ~h;
         6: return ~l;
         default: return 1'b0;
      endcase
   endfunction

   initial begin
      #2000000;
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R12 reset state
      chk(sel_secondary, 1'b0, "R12 sel");
      chk(holdover, 1'b0, "R12 hold");
      chk(pwr_pri, 1'b0, "R12 pwr_pri");
      chk(pwr_sec, 1'b0, "R12 pwr_sec");

      // R11 never locked: no holdover on a lost reference
      cfg_hold_en = 1; pri_good = 0; dld = 0;
      step(3);
      chk(holdover, 1'b0, "R11 no prior lock");
      cfg_hold_en = 0; pri_good = 1;

      // R1 / R8 manual sweep with bypass
      cfg_deglitch_off = 1;
      for (int k = 0; k < 8; k++) begin
         cfg_use_pin = k[2]; cfg_sel_secondary = k[1]; ref_sel_pin = k[0];
         step(1);
         chk(sel_secondary, k[2] ? k[0] : k[1], "R1 R8 manual");
      end
      cfg_use_pin = 0; cfg_sel_secondary = 0; ref_sel_pin = 0;
      step(1);

      // R7 deglitch timing
      cfg_deglitch_off = 0;
      cfg_sel_secondary = 1;
      step(7);
      chk(sel_secondary, 1'b0, "R7 before count");
      step(1);
      chk(sel_secondary, 1'b1, "R7 at count");
      cfg_sel_secondary = 0;
      step(5);
      cfg_sel_secondary = 1;
      step(10);
      chk(sel_secondary, 1'b1, "R7 withdrawn request");
      cfg_sel_secondary = 0;
      step(8);
      chk(sel_secondary, 1'b0, "R7 return");

      // R2 revertive auto
      cfg_deglitch_off = 1; cfg_auto = 1;
      step(2);
      chk(sel_secondary, 1'b0, "R2 start primary");
      pri_good = 0; step(1);
      chk(sel_secondary, 1'b1, "R2 to secondary");
      pri_good = 1; step(1);
      chk(sel_secondary, 1'b0, "R2 revert");

      // R6 both bad
      pri_good = 0; sec_good = 0; step(3);
      chk(sel_secondary, 1'b0, "R6 keep primary");
      sec_good = 1; step(1);
      chk(sel_secondary, 1'b1, "R6 move");
      sec_good = 0; step(3);
      chk(sel_secondary, 1'b1, "R6 keep secondary");
      pri_good = 1; sec_good = 1; step(1);
      chk(sel_secondary, 1'b0, "R6 recover");

      // R3 non-revertive
      cfg_stay_secondary = 1;
      pri_good = 0; step(1);
      chk(sel_secondary, 1'b1, "R3 switch");
      pri_good = 1; step(5);
      chk(sel_secondary, 1'b1, "R3 stay");
      cfg_stay_secondary = 0; step(1);
      chk(sel_secondary, 1'b0, "R3 release");

      // R4 differential inhibits auto
      cfg_diff_mode = 1;
      pri_good = 0; step(5);
      chk(sel_secondary, 1'b0, "R4 inhibited");
      cfg_sel_secondary = 1; step(1);
      chk(sel_secondary, 1'b1, "R4 manual applies");
      cfg_sel_secondary = 0; pri_good = 1; cfg_diff_mode = 0; step(2);

      // R5 power enables
      for (int k = 0; k < 8; k++) begin
         cfg_auto = k[2]; cfg_pwr_pri = k[1]; cfg_pwr_sec = k[0];
         #1;
         chk(pwr_pri, k[2] | k[1], "R5 pwr_pri");
         chk(pwr_sec, k[2] | k[0], "R5 pwr_sec");
      end
      cfg_diff_mode = 1; cfg_auto = 1; cfg_pwr_pri = 0; cfg_pwr_sec = 0; #1;
      chk(pwr_pri, 1'b0, "R5 diff pwr");
      cfg_diff_mode = 0; cfg_auto = 0; step(2);

      // R11 internal holdover
      cfg_hold_en = 1; cfg_hold_ext = 0; cfg_cmp_en = 0;
      dld = 1; step(2);
      chk(holdover, 1'b0, "R11 ref good");
      pri_good = 0; step(1);
      chk(holdover, 1'b1, "R11 lost ref");
      cfg_mon_sel = 3'd5; #1;
      chk(mon_out, 1'b0, "R13 hold code");
      cfg_cmp_en = 1; lock_cmp = 0; step(1);
      chk(holdover, 1'b0, "R11 comparator low");
      lock_cmp = 1; step(1);
      chk(holdover, 1'b1, "R11 comparator high");
      pri_good = 1; step(1);
      chk(holdover, 1'b0, "R11 ref back");

      // R10 external
      cfg_hold_ext = 1; hold_pin = 1; step(1);
      chk(holdover, 1'b1, "R10 pin high");
      hold_pin = 0; step(1);
      chk(holdover, 1'b0, "R10 pin low");
      hold_pin = 1; step(1);

      // R9 disabled
      cfg_hold_en = 0; pri_good = 0; step(1);
      chk(holdover, 1'b0, "R9 disabled");
      cfg_hold_ext = 0; step(2);
      chk(holdover, 1'b0, "R9 disabled internal");
      pri_good = 1; hold_pin = 0; step(1);

      // R13 monitor sweep on primary, then on secondary
      for (int sd = 0; sd < 2; sd++) begin
         cfg_sel_secondary = sd[0];
         step(1);
         for (int code = 0; code < 8; code++) begin
            for (int v = 0; v < 32; v++) begin
               cfg_mon_sel = 3'(code);
               pri_good = v[0]; sec_good = v[1]; clk_good = v[2]; dld = v[3]; lock_cmp = v[4];
               #1;
               chk(mon_out, mon_exp(code, v[0], v[1], v[2], v[3], v[4], sd[0], 1'b0),
                   "R13 monitor");
            end
         end
      end

      finish_run();
   end

endmodule